// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. When a column command is issued, the controller pulses `start_i` together with the starting column, a burst-length code and an order select. From the next cycle on the block presents one column per beat on `col_o`. It moves to the following beat each time `adv_i` is high, and it marks the final beat of a fixed-length burst with `last_o`.

Every address stays inside the aligned block of columns whose size equals the burst length. Sequential order counts upward and wraps inside that block. Interleaved order flips the low address bits according to the beat number. A full-page burst spans the whole row. It always counts sequentially, wraps from the top column back to column 0, and keeps running until `stop_i` or a new `start_i` arrives. The page width is the parameter `COL_W`, so the page holds 2^COL_W columns.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `valid_o` and `last_o` are 0.
- R2: A cycle with `start_i` high makes `valid_o` high in the next cycle, with `col_o` equal to the sampled `col_i` (beat 0).
- R3: Length codes on `len_i`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The reserved codes 4, 5 and 6 behave as a single beat.
- R4: With `ilv_i`=0 and a fixed length L, beat n addresses the column (start with its low log2(L) bits cleared) plus ((start + n) mod L).
- R5: With `ilv_i`=1 and a fixed length L, the low log2(L) bits of beat n are the start's low bits XOR n, and the upper bits are the start's. For example, L=8 and start 2 give the order 2, 3, 0, 1, 6, 7, 4, 5.
- R6: Every valid column lies in the same aligned block of L columns as the start column. For a full page, that block is the whole row.
- R7: A full-page burst ignores `ilv_i` and counts sequentially modulo 2^COL_W. It never raises `last_o` and never ends by itself.
- R8: `last_o` is high exactly on beat L-1 of a fixed-length burst. An `adv_i` on that beat makes `valid_o` low in the next cycle.
- R9: While a burst is valid and `adv_i`, `start_i` and `stop_i` are low, `col_o`, `valid_o` and `last_o` hold their values.
- R10: `stop_i` without `start_i` makes `valid_o` low in the next cycle.
- R11: `start_i` has priority over `stop_i` and `adv_i`. A start in the middle of a burst, including one on its final advancing beat, restarts the generator at beat 0 with the new parameters.
- R12: `adv_i` while no burst is valid has no effect: `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command: load a new burst |
| col_i | input | COL_W | Starting column |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order |
| adv_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | Burst terminate |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Two functions can meet in one cycle: the natural end of a burst, when `adv_i` arrives on the beat flagged by `last_o`, and a restart by `start_i`. A terminate by `stop_i` can also coincide with a start. Directed cases put `start_i` on the advancing final beat and place `stop_i` alongside `start_i`. The random phase raises start and stop often enough that such overlaps recur. Each case is judged by whether the next cycle shows beat 0 of the new burst, with the new column and length, rather than an idle output.

// File: rtl/sdram_bst_pkg.sv
package sdram_bst_pkg;
   localparam logic [2:0] BLC_ONE  = 3'd0;
   localparam logic [2:0] BLC_TWO  = 3'd1;
   localparam logic [2:0] BLC_FOUR = 3'd2;
   localparam logic [2:0] BLC_8    = 3'd3;
   localparam logic [2:0] BLC_PAGE = 3'd7;

   typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} bst_order_e;
endpackage

// File: rtl/bst_len_decode.sv
module bst_len_decode
   import sdram_bst_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [2:0]       code_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o
);
   localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

   if (COL_W < 3 || COL_W > 16) begin : g_bad_width
      $error("bst_len_decode: COL_W must lie in 3..16");
   end

   always_comb begin
      full_o = 1'b0;
      unique case (code_i)
         BLC_TWO:  mask_o = COL_W'(1);
         BLC_FOUR: mask_o = COL_W'(3);
         BLC_8:    mask_o = COL_W'(7);
         BLC_PAGE: begin
            mask_o = PAGE_MASK;
            full_o = 1'b1;
         end
         default:  mask_o = '0;
      endcase
   end
endmodule

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             adv_i,
   input  logic             full_i,
   input  logic [COL_W-1:0] last_idx_i,
   output logic             valid_o,
   output logic [COL_W-1:0] beat_o,
   output logic             last_o
);
   logic at_end;

   assign at_end = !full_i && (beat_o == last_idx_i);
   assign last_o = valid_o && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         beat_o  <= '0;
      end else if (start_i) begin
         valid_o <= 1'b1;
         beat_o  <= '0;
      end else if (stop_i) begin
         valid_o <= 1'b0;
      end else if (valid_o && adv_i) begin
         if (at_end) valid_o <= 1'b0;
         else        beat_o  <= beat_o + 1'b1;
      end
   end

   // R8: advancing on the final beat closes the burst
   a_r8_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && adv_i && !start_i) |=> !valid_o);
   // R10: terminate without a start
   a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !valid_o);
   // R9: no advance holds the beat
   a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !adv_i && !start_i && !stop_i) |=> (valid_o && $stable(beat_o)));
   // R12: advance while idle has no effect
   a_r12_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);
endmodule

// File: rtl/bst_col_map.sv
module bst_col_map #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] low;

   assign seq_low = (base_i + beat_i) & mask_i;

   if (ILV_EN) begin : g_ilv
      logic [COL_W-1:0] ilv_low;
      assign ilv_low = (base_i ^ beat_i) & mask_i;
      assign low     = ilv_i ? ilv_low : seq_low;
   end else begin : g_seq_only
      logic unused_ilv;
      assign unused_ilv = ilv_i;
      assign low        = seq_low;
   end

   assign col_o = (base_i & ~mask_i) | low;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_bst_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [2:0]       len_i,
   input  logic             ilv_i,
   input  logic             adv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   bst_order_e       ord_q;
   logic [COL_W-1:0] beat;

   bst_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i (len_i),
      .mask_o (dec_mask),
      .full_o (dec_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
         ord_q  <= ORD_SEQ;
      end else if (start_i) begin
         base_q <= col_i;
         mask_q <= dec_mask;
         full_q <= dec_full;
         ord_q  <= (ilv_i && !dec_full) ? ORD_ILV : ORD_SEQ;
      end
   end

   bst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .adv_i      (adv_i),
      .full_i     (full_q),
      .last_idx_i (mask_q),
      .valid_o    (valid_o),
      .beat_o     (beat),
      .last_o     (last_o)
   );

   bst_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .base_i (base_q),
      .beat_i (beat),
      .mask_i (mask_q),
      .ilv_i  (ord_q == ORD_ILV),
      .col_o  (col_o)
   );

   // R2: a start presents its own column as beat 0
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(col_i)));
   // R6: columns stay inside the aligned block of the start column
   a_r6_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((col_o ^ base_q) & ~mask_q) == '0));
   // R7: a full-page start never produces a last beat next cycle
   a_r7_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_i == BLC_PAGE) |=> !last_o);
   // R9: columns hold while nothing happens
   a_r9_hold_col: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !adv_i && !start_i && !stop_i) |=> $stable(col_o));
endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] col_i = '0;
   logic [2:0]    len_i = '0;
   logic          ilv_i = 1'b0;
   logic          adv_i = 1'b0;
   logic          stop_i = 1'b0;
   logic [CW-1:0] col_o;
   logic          valid_o, last_o;

   int n_vec = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // reference state
   bit          m_valid = 1'b0;
   logic [CW-1:0] m_start = '0;
   logic [2:0]  m_len = '0;
   bit          m_ilv = 1'b0;
   logic [CW-1:0] m_n = '0;

   always #2 clk = ~clk;

   sdram_burst_colgen #(.COL_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
      .len_i(len_i), .ilv_i(ilv_i), .adv_i(adv_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   function automatic int blen(input logic [2:0] c);
      case (c)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 1 << CW;
         default: return 1;
      endcase
   endfunction

   function automatic logic [CW-1:0] f_col(input logic [CW-1:0] s,
                                           input logic [2:0] c, input bit ilv,
                                           input logic [CW-1:0] n);
      int L, lo, blk;
      L   = blen(c);
      lo  = int'(s) % L;
      blk = int'(s) - lo;
      if (ilv && c != 3'd7) return CW'(blk + (lo ^ int'(n)));
      return CW'(blk + ((lo + int'(n)) % L));
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick(input string tag);
      bit fin;
      @(posedge clk);
      fin = (m_len != 3'd7) && (int'(m_n) == blen(m_len) - 1);
      if (!rst_n) m_valid = 1'b0;
      else if (start_i) begin
         m_valid = 1'b1; m_start = col_i; m_len = len_i; m_ilv = ilv_i; m_n = '0;
      end else if (stop_i) m_valid = 1'b0;
      else if (m_valid && adv_i) begin
         if (fin) m_valid = 1'b0;
         else     m_n = m_n + 1'b1;
      end
      @(negedge clk);
      chk(tag, "valid", int'(valid_o), int'(m_valid));
      if (m_valid) begin
         chk(tag, "col", int'(col_o), int'(f_col(m_start, m_len, m_ilv, m_n)));
         chk(tag, "last", int'(last_o), int'(m_len != 3'd7 && int'(m_n) == blen(m_len) - 1));
      end else
         chk(tag, "last", int'(last_o), 0);
   endtask

   task automatic drive(input bit s, input int c, input int l, input bit i,
                        input bit a, input bit p);
      start_i = s; col_i = CW'(c); len_i = 3'(l); ilv_i = i; adv_i = a; stop_i = p;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int exp8 [8] = '{2, 3, 0, 1, 6, 7, 4, 5};
      void'($urandom(32'h5d1e_0042));
      @(negedge clk);
      drive(1, 5, 3, 0, 1, 0);
      tick("R1");
      tick("R1");
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 1, 0);
      tick("R1");
      tick("R12");                       // R12: advance while idle
      // R5 directed order
      drive(1, 2, 3, 1, 0, 0);
      tick("R2");
      for (int k = 0; k < 8; k++) begin
         chk("R5", "order", int'(col_o), exp8[k]);
         drive(0, 0, 0, 0, 1, 0);
         tick("R5");
      end
      // R4 sequential length 4 with a hold
      drive(1, 9'h0d6, 2, 0, 0, 0);
      tick("R4");
      drive(0, 0, 0, 0, 0, 0);
      tick("R9");
      tick("R9");
      drive(0, 0, 0, 0, 1, 0);
      repeat (4) tick("R4");
      // R7 full page wraps and ignores the interleave bit
      drive(1, 510, 7, 1, 0, 0);
      tick("R7");
      drive(0, 0, 0, 0, 1, 0);
      tick("R7");
      tick("R7");
      chk("R7", "wrap", int'(col_o), 0);
      tick("R6");
      drive(0, 0, 0, 0, 0, 1);
      tick("R10");
      // R3 reserved code is a single beat
      drive(1, 77, 5, 1, 0, 0);
      tick("R3");
      chk("R3", "last", int'(last_o), 1);
      drive(0, 0, 0, 0, 1, 0);
      tick("R8");
      // R11 start on the final advancing beat
      drive(1, 40, 1, 0, 0, 0);
      tick("R11");
      drive(0, 0, 0, 0, 1, 0);
      tick("R8");
      drive(1, 300, 3, 1, 1, 0);
      tick("R11");
      chk("R11", "col", int'(col_o), 300);
      // R11 start with stop in the same cycle
      drive(1, 123, 2, 1, 1, 1);
      tick("R11");
      drive(0, 0, 0, 0, 1, 0);
      tick("R5");
      // random phase
      for (int c = 0; c < 6000; c++) begin
         string tg;
         drive(($urandom % 12) == 0, int'($urandom), int'($urandom % 8),
               bit'($urandom), ($urandom % 10) < 7, ($urandom % 40) == 0);
         if (!m_valid)            tg = "R12";
         else if (m_len == 3'd7)  tg = "R7";
         else if (m_ilv)          tg = "R5";
         else                     tg = "R4";
         tick(tg);
      end
      finish_run();
   end
endmodule